// File: doc/BRIEF.md
# Segmented Matched-Filter Acquisition Correlator

This block searches for a known spreading code in a stream of complex baseband samples. Each accepted sample enters a sliding window of the last `N = 8*SPM` samples, where `SPM` is the number of samples per millisecond. The window therefore spans 8 ms of signal. It is correlated against a replica code held in a register bank.

The window is cut into four equal segments of 2 ms each. Within a segment, the I and Q products are summed coherently, and the segment power is the square of the I sum plus the square of the Q sum. The four powers are added non-coherently to form one detection metric. Adding powers rather than signed sums keeps most of the gain of a long window while tolerating a sign change between segments.

Each metric leaves on a valid/ready output stream together with its code phase. A peak tracker keeps the largest metric seen and its phase. A sticky detect flag reports whether any metric has exceeded a programmable threshold.

Back-pressure rules: an input sample is taken on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is low exactly when a metric is waiting (`m_valid`) and `m_ready` is low. While stalled, the waiting metric and its phase hold steady.

Top module: `acq_mf_corr`

## Requirements
- R1: The window holds the last N=8*SPM accepted samples, oldest first, and replica chip k multiplies window position k. A chip bit of 0 means +1 (the sample passes unchanged) and a chip bit of 1 means -1 (the sample is negated). Segment s covers positions s*L to s*L+L-1, with L=2*SPM. Segment sums are exact, because their width covers the full segment range.
- R2: The metric equals the sum over the four segments of (I sum)^2 + (Q sum)^2, on MW bits wide enough that it never overflows.
- R3: No metric is produced until N samples have been accepted since reset. After that, every accepted sample yields one metric with `m_valid` high from the next clock edge. The metric's `m_phase` is the zero-based index, counted since reset, of the oldest sample in its window.
- R4: `s_ready` = !(`m_valid` && !`m_ready`). While `m_valid` is high and `m_ready` is low, `m_valid`, `m_metric` and `m_phase` stay stable.
- R5: The peak register takes a new metric and its phase only when the metric is strictly greater than the stored peak, so the first occurrence of a maximum is kept. The stored peak never decreases except through a clear.
- R6: `detect` is set when a produced metric is strictly greater than `threshold`, and it then stays set until a clear or reset. A metric equal to the threshold does not set it.
- R7: A one-cycle `peak_clear` zeroes the peak metric, the peak phase and `detect` on the next edge. It takes priority over a metric produced on the same edge, and that metric is not tracked.
- R8: Replica chip `code_addr` takes `code_bit` on an edge where `load_en` and `code_wr` are both high. A write with `load_en` low has no effect.
- R9: Reset clears the sample history, the fill and index counters, `m_valid`, the peak register and `detect`. The replica bank keeps its contents through reset.
- R10: If the signal's sign is reversed at a segment boundary, the metric of the aligned window is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_i | input | 2 | Signed in-phase sample |
| s_q | input | 2 | Signed quadrature sample |
| m_valid | output | 1 | Metric valid |
| m_ready | input | 1 | Consumer takes the metric |
| m_metric | output | MW | Summed segment power |
| m_phase | output | PW | Index of the window's oldest sample |
| load_en | input | 1 | Enables replica writes |
| code_wr | input | 1 | Replica write strobe |
| code_addr | input | log2(N) | Replica chip index |
| code_bit | input | 1 | Replica chip value (0 = +1, 1 = -1) |
| threshold | input | MW | Detection threshold |
| peak_clear | input | 1 | Clears peak and detect |
| peak_metric | output | MW | Largest metric since clear |
| peak_phase | output | PW | Phase of that metric |
| detect | output | 1 | Sticky threshold-exceeded flag |

## Verification
The assertions watch, on every cycle, the stream rules: no metric before the window fills, a stalled metric held stable, and the ready and stall relation. They also watch that the peak never falls without a clear, that the detect flag is sticky, that a clear zeroes the tracker, and that the replica bank is frozen while loading is disabled. Only the bench's scenarios can show that each metric value matches an independent correlation of the samples sent and that a code buried in noise is found at its true offset. The bench scenarios also show the strict threshold comparison, the insensitivity to a sign reversal between segments, and the priority of a clear over a same-cycle update.

// File: rtl/acq_mf_pkg.sv
package acq_mf_pkg;
  localparam int SEGS = 4;

  typedef struct packed {
    logic signed [1:0] i;
    logic signed [1:0] q;
  } iq_t;
endpackage

// File: rtl/mf_code_bank.sv
module mf_code_bank #(
  parameter int N = 32,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          load_en,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          chip,
  output logic [N-1:0]  code
);
  // replica bank: not reset, written only while loading is enabled
  always_ff @(posedge clk) begin
    if (load_en && wr) code[addr] <= chip;
  end
endmodule

// File: rtl/mf_segment.sv
module mf_segment import acq_mf_pkg::*; #(
  parameter int L = 8,
  localparam int SW = $clog2(2*L) + 2,
  localparam int PWR_W = $clog2(8*L*L + 1)
) (
  input  iq_t [L-1:0]      smp,
  input  logic [L-1:0]     chips,
  output logic [PWR_W-1:0] power
);
  logic signed [SW-1:0]   acc_i, acc_q;
  logic signed [2*SW-1:0] sq_i, sq_q;

  // coherent sums: chip 1 negates the sample
  always_comb begin
    acc_i = '0;
    acc_q = '0;
    for (int k = 0; k < L; k++) begin
      logic signed [SW-1:0] xi, xq;
      xi = SW'($signed(smp[k].i));
      xq = SW'($signed(smp[k].q));
      acc_i = acc_i + (chips[k] ? -xi : xi);
      acc_q = acc_q + (chips[k] ? -xq : xq);
    end
    sq_i  = acc_i * acc_i;
    sq_q  = acc_q * acc_q;
    power = PWR_W'(sq_i + sq_q);
  end
endmodule

// File: rtl/mf_peak_hold.sv
module mf_peak_hold #(
  parameter int MW = 12,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          upd,
  input  logic [MW-1:0] metric,
  input  logic [PW-1:0] phase,
  input  logic [MW-1:0] threshold,
  output logic [MW-1:0] peak_metric,
  output logic [PW-1:0] peak_phase,
  output logic          detect
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      peak_metric <= '0;
      peak_phase  <= '0;
      detect      <= 1'b0;
    end else if (upd) begin
      if (metric > peak_metric) begin
        peak_metric <= metric;
        peak_phase  <= phase;
      end
      if (metric > threshold) detect <= 1'b1;
    end
  end
endmodule

// File: rtl/acq_mf_corr.sv
module acq_mf_corr import acq_mf_pkg::*; #(
  parameter int SPM = 4,
  parameter int PW  = 16,
  localparam int N  = 8 * SPM,
  localparam int L  = 2 * SPM,
  localparam int AW = $clog2(N),
  localparam int PWR_W = $clog2(8*L*L + 1),
  localparam int MW = $clog2(SEGS*8*L*L + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic signed [1:0] s_i,
  input  logic signed [1:0] s_q,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [MW-1:0]     m_metric,
  output logic [PW-1:0]     m_phase,
  input  logic              load_en,
  input  logic              code_wr,
  input  logic [AW-1:0]     code_addr,
  input  logic              code_bit,
  input  logic [MW-1:0]     threshold,
  input  logic              peak_clear,
  output logic [MW-1:0]     peak_metric,
  output logic [PW-1:0]     peak_phase,
  output logic              detect
);
  iq_t [N-1:0]      hist;      // hist[0] is the newest stored sample
  iq_t [N-1:0]      win;       // next window, win[0] oldest
  iq_t              in_smp;
  logic [N-1:0]     code_q;
  logic [PWR_W-1:0] pwr [SEGS];
  logic [MW-1:0]    metric;
  logic [AW-1:0]    fill;
  logic [PW-1:0]    seq;
  logic             accept, full;

  assign s_ready = !(m_valid && !m_ready);
  assign accept  = s_valid && s_ready;
  assign full    = (fill == AW'(N-1));

  always_comb begin
    in_smp.i = s_i;
    in_smp.q = s_q;
    for (int k = 0; k < N-1; k++) win[k] = hist[N-2-k];
    win[N-1] = in_smp;
  end

  mf_code_bank #(.N(N)) u_bank (
    .clk(clk), .load_en(load_en), .wr(code_wr),
    .addr(code_addr), .chip(code_bit), .code(code_q)
  );

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    mf_segment #(.L(L)) u_seg (
      .smp(win[s*L +: L]), .chips(code_q[s*L +: L]), .power(pwr[s])
    );
  end

  // non-coherent combination of segment powers
  always_comb begin
    metric = '0;
    for (int s = 0; s < SEGS; s++) metric = metric + MW'(pwr[s]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      fill    <= '0;
      seq     <= '0;
      m_valid <= 1'b0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (accept) begin
        hist <= {hist[N-2:0], in_smp};
        seq  <= seq + 1'b1;
        if (!full) fill <= fill + 1'b1;
        if (full) begin
          m_valid  <= 1'b1;
          m_metric <= metric;
          m_phase  <= seq - PW'(N-1);
        end
      end
    end
  end

  mf_peak_hold #(.MW(MW), .PW(PW)) u_peak (
    .clk(clk), .rst(rst), .clear(peak_clear), .upd(accept && full),
    .metric(metric), .phase(seq - PW'(N-1)), .threshold(threshold),
    .peak_metric(peak_metric), .peak_phase(peak_phase), .detect(detect)
  );
endmodule

// File: rtl/acq_mf_corr_chk.sv
module acq_mf_corr_chk #(
  parameter int N  = 32,
  parameter int MW = 12,
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [MW-1:0] m_metric,
  input logic [PW-1:0] m_phase,
  input logic          load_en,
  input logic [N-1:0]  code,
  input logic [MW-1:0] threshold,
  input logic          peak_clear,
  input logic [MW-1:0] peak_metric,
  input logic          detect
);
  localparam int CW = $clog2(N + 1);
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= '0;
    else if (s_valid && s_ready && seen < CW'(N)) seen <= seen + 1'b1;
  end

  assert_no_early_out_R3: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready && seen < CW'(N-1)) |=> !m_valid);

  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_metric) && $stable(m_phase)));

  assert_stall_ready_R4: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |-> !s_ready);

  assert_peak_rises_R5: assert property (@(posedge clk) disable iff (rst)
    !peak_clear |=> peak_metric >= $past(peak_metric));

  assert_detect_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (detect && !peak_clear) |=> detect);

  assert_detect_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(detect) |-> peak_metric > $past(threshold));

  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (rst)
    peak_clear |=> (peak_metric == '0 && !detect));

  assert_code_locked_R8: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(code));
endmodule

bind acq_mf_corr acq_mf_corr_chk #(.N(N), .MW(MW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_metric(m_metric), .m_phase(m_phase),
  .load_en(load_en), .code(code_q), .threshold(threshold),
  .peak_clear(peak_clear), .peak_metric(peak_metric), .detect(detect)
);

// File: tb/acq_mf_corr_tb.sv
module acq_mf_corr_tb;
  localparam int SPM = 4;
  localparam int PW  = 16;
  localparam int N   = 8 * SPM;
  localparam int L   = 2 * SPM;
  localparam int AW  = $clog2(N);
  localparam int MW  = $clog2(4*8*L*L + 1);

  logic clk = 0, rst = 1;
  logic s_valid = 0, s_ready;
  logic signed [1:0] s_i = 0, s_q = 0;
  logic m_valid, m_ready = 1;
  logic [MW-1:0] m_metric, peak_metric;
  logic [PW-1:0] m_phase, peak_phase;
  logic load_en = 0, code_wr = 0, code_bit = 0, peak_clear = 0, detect;
  logic [AW-1:0] code_addr = 0;
  logic [MW-1:0] threshold = '1;

  int checks = 0, fails = 0;
  int sent_i [1024], sent_q [1024];
  int nsent = 0, nout = 0, exp_phase = 0;
  bit code_b [N];

  always #2 clk = ~clk;

  acq_mf_corr #(.SPM(SPM), .PW(PW)) u_dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .m_valid(m_valid), .m_ready(m_ready),
    .m_metric(m_metric), .m_phase(m_phase), .load_en(load_en),
    .code_wr(code_wr), .code_addr(code_addr), .code_bit(code_bit),
    .threshold(threshold), .peak_clear(peak_clear),
    .peak_metric(peak_metric), .peak_phase(peak_phase), .detect(detect)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // independent correlation model from R1/R2
  function automatic int model(int p);
    int tot;
    tot = 0;
    for (int s = 0; s < 4; s++) begin
      int si, sq;
      si = 0; sq = 0;
      for (int k = 0; k < L; k++) begin
        int c;
        c = code_b[s*L+k] ? -1 : 1;
        si += sent_i[p+s*L+k] * c;
        sq += sent_q[p+s*L+k] * c;
      end
      tot += si*si + sq*sq;
    end
    return tot;
  endfunction

  // largest model metric over the stream; strict > keeps first
  task automatic model_peak(output int pm, output int pp, output int anyover, input int thr);
    pm = 0; pp = 0; anyover = 0;
    for (int p = 0; p + N <= nsent; p++) begin
      int v;
      v = model(p);
      if (v > pm) begin pm = v; pp = p; end
      if (v > thr) anyover = 1;
    end
  endtask

  // output monitor: R1, R2, R3 on every metric taken
  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      chk(nsent >= N, "R3", "metric before window full", nsent, N);
      chk(int'(m_phase) == exp_phase, "R3", "metric phase", int'(m_phase), exp_phase);
      chk(int'(m_metric) == model(int'(m_phase)), "R2", "metric value",
          int'(m_metric), model(int'(m_phase)));
      exp_phase++;
      nout++;
    end
  end

  task automatic do_reset();
    rst = 1; s_valid = 0; peak_clear = 0; m_ready = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    nsent = 0; nout = 0; exp_phase = 0;
  endtask

  task automatic send(int vi, int vq);
    s_i = 2'(vi); s_q = 2'(vq); s_valid = 1;
    forever begin
      @(negedge clk);
      if (s_ready) break;
    end
    @(posedge clk);
    sent_i[nsent] = vi; sent_q[nsent] = vq; nsent++;
    #1 s_valid = 0;
  endtask

  task automatic send_noise(int n);
    for (int k = 0; k < n; k++)
      send($urandom_range(0, 2) - 1, $urandom_range(0, 2) - 1);
  endtask

  // aligned code; flip negates segments 2,3; gaps zero two samples
  task automatic send_code(bit flip, bit gaps);
    for (int k = 0; k < N; k++) begin
      int v;
      v = code_b[k] ? -1 : 1;
      if (flip && k >= 2*L) v = -v;
      if (gaps && (k == 3 || k == 20)) v = 0;
      send(v, v);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset_state();  // R9
    do_reset();
    @(negedge clk);
    chk(!m_valid, "R9", "m_valid after reset", m_valid, 0);
    chk(s_ready, "R4", "s_ready after reset", s_ready, 1);
    chk(peak_metric == 0, "R9", "peak after reset", int'(peak_metric), 0);
    chk(!detect, "R9", "detect after reset", detect, 0);
  endtask

  task automatic t_load_code();  // R8
    bit [6:0] lf;
    lf = 7'h5A;
    @(posedge clk); #1 load_en = 1;
    for (int k = 0; k < N; k++) begin
      code_b[k] = lf[0];
      lf = {lf[5:0], lf[6] ^ lf[5]};
      code_wr = 1; code_addr = AW'(k); code_bit = code_b[k];
      @(posedge clk); #1;
    end
    code_wr = 0; load_en = 0;
    // write attempts with loading disabled must not land (checked through metrics)
    code_wr = 1; code_addr = 0; code_bit = !code_b[0];
    @(posedge clk); #1 code_addr = 5; code_bit = !code_b[5];
    @(posedge clk); #1 code_wr = 0;
  endtask

  task automatic t_acquire();  // R1 R3 R5 R6 R8
    int pm, pp, ov;
    do_reset();
    threshold = 300;
    send_noise(11);
    send_code(0, 1);
    send_noise(20);
    idle(3);
    model_peak(pm, pp, ov, 300);
    chk(nout == nsent - N + 1, "R3", "metric count", nout, nsent - N + 1);
    chk(pp == 11, "R1", "model peak at injected offset", pp, 11);
    chk(int'(peak_phase) == 11, "R5", "peak phase", int'(peak_phase), 11);
    chk(int'(peak_metric) == pm, "R8", "peak metric with locked bank", int'(peak_metric), pm);
    chk(detect == 1, "R6", "detect raised", detect, 1);
  endtask

  task automatic t_strict_threshold();  // R6 R9
    int pm, pp, ov;
    do_reset();
    threshold = 512;
    send_noise(3);
    send_code(0, 0);
    send_noise(8);
    idle(3);
    model_peak(pm, pp, ov, 512);
    chk(int'(peak_metric) == pm, "R9", "bank kept across reset", int'(peak_metric), pm);
    chk(pm == 512, "R6", "clean match metric", pm, 512);
    chk(detect == ov, "R6", "equal metric does not detect", detect, ov);
    do_reset();
    threshold = 511;
    send_noise(3);
    send_code(0, 0);
    send_noise(8);
    idle(3);
    chk(detect == 1, "R6", "metric above threshold detects", detect, 1);
    chk(int'(peak_phase) == 3, "R5", "peak phase clean", int'(peak_phase), 3);
  endtask

  task automatic t_reversal();  // R10
    do_reset();
    threshold = '1;
    send_noise(5);
    send_code(1, 0);
    send_noise(6);
    idle(3);
    chk(int'(peak_metric) == 512, "R10", "metric with segment sign flip",
        int'(peak_metric), 512);
    chk(int'(peak_phase) == 5, "R10", "phase with segment sign flip",
        int'(peak_phase), 5);
  endtask

  task automatic t_backpressure();  // R4
    logic [MW-1:0] held;
    logic [PW-1:0] hph;
    do_reset();
    threshold = '1;
    send_noise(N - 1);
    send(1, -1);
    m_ready = 0;
    @(negedge clk);
    chk(m_valid == 1, "R4", "metric waiting", m_valid, 1);
    chk(s_ready == 0, "R4", "s_ready low while stalled", s_ready, 0);
    held = m_metric; hph = m_phase;
    repeat (3) @(negedge clk);
    chk(m_metric == held && m_phase == hph, "R4", "metric held in stall",
        int'(m_metric), int'(held));
    chk(s_ready == 0, "R4", "s_ready still low", s_ready, 0);
    @(posedge clk); #1 m_ready = 1;
    idle(2);
    chk(nout == 1, "R4", "stalled metric delivered once", nout, 1);
  endtask

  task automatic t_clear();  // R7 R5
    int v;
    @(posedge clk); #1 peak_clear = 1;
    @(posedge clk); #1 peak_clear = 0;
    chk(peak_metric == 0 && peak_phase == 0, "R7", "peak cleared", int'(peak_metric), 0);
    chk(!detect, "R7", "detect cleared", detect, 0);
    send_code(0, 0);           // phase 32 reaches 512 at its last sample
    peak_clear = 1;
    send(1, 1);                // accepted on the same edge as the clear
    peak_clear = 0;
    idle(1);
    chk(peak_metric == 0, "R7", "clear beats same-edge update", int'(peak_metric), 0);
    send(-1, 0);
    idle(2);
    v = model(nsent - N);
    chk(int'(peak_metric) == v, "R5", "peak after clear", int'(peak_metric), v);
    chk(int'(peak_phase) == (v > 0 ? nsent - N : 0), "R5", "peak phase after clear",
        int'(peak_phase), (v > 0 ? nsent - N : 0));
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset_state();
    t_load_code();
    t_acquire();
    t_strict_threshold();
    t_reversal();
    t_backpressure();
    t_clear();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule